// File: doc/BRIEF.md
# Calendar Time Counter with Deferred Register Commit

This block keeps a running wall-clock calendar of seconds, minutes, hours, day of month, month and a six-bit year count. The year count is measured from 1970, so the block covers 1970 to 2033. The calendar advances by one second on each single-cycle pulse of a seconds tick input. A simple register port reads the live counters at any time. Software can read the time and date words in a loop until two consecutive reads agree.

Software sets a new time or date by writing a packed word. The word is not loaded into the counters at once. It is held as pending, and a per-word busy flag is raised in the control register. On the next seconds tick the pending words are loaded and the busy flags drop. Software polls the control register until the relevant flag is clear.

The date word carries a stored leap flag that selects 28 or 29 days for February. When the year count rolls over, the block recomputes the leap flag from the new year.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time word reads 0 (00:00:00), the date word reads day 1, month 1, year count 0 with the leap flag clear (0x0000_0101), and the control word reads 0.
- R2: The time word at offset 0x14 holds seconds in bits [5:0], minutes in [13:8] and hours in [20:16]. The date word at offset 0x10 holds the day in [4:0], the month (1 to 12) in [11:8], the year count in [21:16] and the leap flag in bit 22. Reads return the live counter values combinationally.
- R3: Each tick that commits nothing advances the seconds by one. Seconds and minutes wrap from 59 to 0 with a carry, and hours wrap from 23 to 0 with a carry into the day.
- R4: The day wraps to 1 with a carry into the month after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12. The month wraps from 12 to 1 with a carry into the year.
- R5: In month 2 the day wraps after 29 when the leap flag is set, and after 28 when it is clear.
- R6: A year carry increments the year count, wrapping from 63 to 0. It also sets the leap flag to 1 exactly when the new year count modulo 4 equals 2, which is when the calendar year is divisible by 4.
- R7: A write to the time word sets control bit 8 and stores the value as pending. On the first tick after the write cycle, the pending time is loaded into the counters and bit 8 clears. A tick in the same cycle as the write does not commit that write. A second write before the commit replaces the pending value.
- R8: A write to the date word sets control bit 7 and is committed on the next tick in the same way. On any tick that commits a time or a date, neither word advances.
- R9: The control word reads 0 in every bit except bits 8 and 7; bit 9 always reads 0. Writes to the control offset and to unmapped offsets change nothing. Without a tick the counters hold their value.
- R10: While a write is pending, reads of its word return the running counter value, not the pending one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The read port is driven combinationally from state, so a corrupted counter or busy flag shows at the port in the same cycle it is read. A wrong carry or month length first appears at the tick that crosses the boundary, one cycle after the tick pulse. A busy flag that clears too early or too late shows in the control word one cycle after the write or the committing tick. It also shows as a time or date word that changes at the wrong tick. The vector table places each boundary one second away and reads back both words after the commit tick and after the advance tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int REG_W = 32;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 5;
  localparam int MON_W = 4;
  localparam int YR_W  = 6;

  typedef struct packed {
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } cal_time_t;

  typedef struct packed {
    logic             leap;
    logic [YR_W-1:0]  yr;
    logic [MON_W-1:0] mon;
    logic [DAY_W-1:0] day;
  } cal_date_t;

  function automatic logic [REG_W-1:0] time_to_word(cal_time_t t);
    return {11'd0, t.hr, 2'd0, t.min, 2'd0, t.sec};
  endfunction

  function automatic logic [REG_W-1:0] date_to_word(cal_date_t d);
    return {9'd0, d.leap, d.yr, 4'd0, d.mon, 3'd0, d.day};
  endfunction

  function automatic cal_time_t word_to_time(logic [REG_W-1:0] w);
    cal_time_t t;
    t.sec = w[5:0];
    t.min = w[13:8];
    t.hr  = w[20:16];
    return t;
  endfunction

  function automatic cal_date_t word_to_date(logic [REG_W-1:0] w);
    cal_date_t d;
    d.day  = w[4:0];
    d.mon  = w[11:8];
    d.yr   = w[21:16];
    d.leap = w[22];
    return d;
  endfunction

  function automatic logic [DAY_W-1:0] month_len(logic [MON_W-1:0] mon, logic leap);
    case (mon)
      4'd2:                     return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_wrap_cnt.sv
module cal_wrap_cnt #(
  parameter int W = 6
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] top_val,
  input  logic [W-1:0] base_val,
  input  logic         inc,
  output logic [W-1:0] nxt,
  output logic         carry
);
  // A field at or past its top value restarts at base on increment.
  assign carry = inc && (cur >= top_val);
  always_comb begin
    if (!inc)      nxt = cur;
    else if (carry) nxt = base_val;
    else           nxt = cur + W'(1);
  end
endmodule

// File: rtl/cal_commit.sv
module cal_commit
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      wr_time,
  input  logic      wr_date,
  input  cal_time_t new_time,
  input  cal_date_t new_date,
  output cal_time_t pend_time,
  output cal_date_t pend_date,
  output logic      busy_time,
  output logic      busy_date
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_time <= '0;
      pend_date <= '0;
      busy_time <= 1'b0;
      busy_date <= 1'b0;
    end else begin
      if (wr_time) begin
        pend_time <= new_time;
        busy_time <= 1'b1;
      end else if (tick) begin
        busy_time <= 1'b0;
      end
      if (wr_date) begin
        pend_date <= new_date;
        busy_date <= 1'b1;
      end else if (tick) begin
        busy_date <= 1'b0;
      end
    end
  end

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_time && !tick |=> busy_time);
  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_time && tick && !wr_time |=> !busy_time);
  // R8
  date_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_date |=> busy_date);
endmodule

// File: rtl/cal_counters.sv
module cal_counters
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      ld_time,
  input  logic      ld_date,
  input  cal_time_t time_in,
  input  cal_date_t date_in,
  output cal_time_t time_q,
  output cal_date_t date_q
);
  localparam logic [DAY_W-1:0] DAY_BASE = DAY_W'(1);
  localparam logic [MON_W-1:0] MON_BASE = MON_W'(1);
  localparam logic [MON_W-1:0] MON_TOP  = MON_W'(12);

  logic [SEC_W-1:0] sec_n;
  logic [MIN_W-1:0] min_n;
  logic [HR_W-1:0]  hr_n;
  logic [DAY_W-1:0] day_n, dim;
  logic [MON_W-1:0] mon_n;
  logic [YR_W-1:0]  yr_n;
  logic c_sec, c_min, c_hr, c_day, c_mon;
  logic leap_n;

  assign dim = month_len(date_q.mon, date_q.leap);

  cal_wrap_cnt #(.W(SEC_W)) u_sec (.cur(time_q.sec), .top_val(SEC_W'(59)),
    .base_val('0), .inc(tick), .nxt(sec_n), .carry(c_sec));
  cal_wrap_cnt #(.W(MIN_W)) u_min (.cur(time_q.min), .top_val(MIN_W'(59)),
    .base_val('0), .inc(c_sec), .nxt(min_n), .carry(c_min));
  cal_wrap_cnt #(.W(HR_W)) u_hr (.cur(time_q.hr), .top_val(HR_W'(23)),
    .base_val('0), .inc(c_min), .nxt(hr_n), .carry(c_hr));
  cal_wrap_cnt #(.W(DAY_W)) u_day (.cur(date_q.day), .top_val(dim),
    .base_val(DAY_BASE), .inc(c_hr), .nxt(day_n), .carry(c_day));
  cal_wrap_cnt #(.W(MON_W)) u_mon (.cur(date_q.mon), .top_val(MON_TOP),
    .base_val(MON_BASE), .inc(c_day), .nxt(mon_n), .carry(c_mon));

  // Year count wraps naturally; calendar year divisible by 4 when count mod 4 == 2.
  assign yr_n   = c_mon ? date_q.yr + YR_W'(1) : date_q.yr;
  assign leap_n = c_mon ? (yr_n[1:0] == 2'd2) : date_q.leap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '0;
      date_q <= '{leap: 1'b0, yr: '0, mon: MON_BASE, day: DAY_BASE};
    end else if (tick) begin
      if (ld_time || ld_date) begin
        if (ld_time) time_q <= time_in;
        if (ld_date) date_q <= date_in;
      end else begin
        time_q <= '{hr: hr_n, min: min_n, sec: sec_n};
        date_q <= '{leap: leap_n, yr: yr_n, mon: mon_n, day: day_n};
      end
    end
  end

  // R9
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(time_q) && $stable(date_q));
  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ld_time && !ld_date && (time_q.sec < SEC_W'(59))
    |=> time_q.sec == $past(time_q.sec) + SEC_W'(1));
  // R6
  leap_on_year_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ld_time && !ld_date
    |=> (date_q.yr == $past(date_q.yr)) || (date_q.leap == (date_q.yr[1:0] == 2'd2)));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS   = 'h00,
  parameter logic [ADDR_W-1:0] DATE_OFS   = 'h10,
  parameter logic [ADDR_W-1:0] TIME_OFS   = 'h14,
  parameter int                BUSY_T_BIT = 8,
  parameter int                BUSY_D_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  logic      wr_time, wr_date, busy_time, busy_date;
  cal_time_t pend_time, time_q;
  cal_date_t pend_date, date_q;
  logic      unused_wbits;

  assign wr_time = reg_wr && (reg_addr == TIME_OFS);
  assign wr_date = reg_wr && (reg_addr == DATE_OFS);
  assign unused_wbits = ^{reg_wdata[31:23], reg_wdata[15:14], reg_wdata[7:6]};

  cal_commit u_commit (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick),
    .wr_time(wr_time), .wr_date(wr_date),
    .new_time(word_to_time(reg_wdata)), .new_date(word_to_date(reg_wdata)),
    .pend_time(pend_time), .pend_date(pend_date),
    .busy_time(busy_time), .busy_date(busy_date)
  );

  cal_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick),
    .ld_time(busy_time), .ld_date(busy_date),
    .time_in(pend_time), .date_in(pend_date),
    .time_q(time_q), .date_q(date_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_OFS) begin
      reg_rdata[BUSY_T_BIT] = busy_time;
      reg_rdata[BUSY_D_BIT] = busy_date;
    end else if (reg_addr == DATE_OFS) begin
      reg_rdata = date_to_word(date_q);
    end else if (reg_addr == TIME_OFS) begin
      reg_rdata = time_to_word(time_q);
    end
  end

  // R10
  pending_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_time && !sec_tick |=> $stable(time_q));
endmodule

// File: tb/rtc_calendar_tb_top.sv
module rtc_calendar_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int checks = 0;
  int failures = 0;

  localparam logic [7:0] A_CTRL = 8'h00, A_DATE = 8'h10, A_TIME = 8'h14;

  always #4 clk = ~clk;

  rtc_calendar dut_i (.clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [31:0] mk_t(int h, int m, int s);
    return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction
  function automatic logic [31:0] mk_d(int lp, int y, int mo, int d);
    return (32'(lp) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
  endfunction

  localparam int NV = 13;
  localparam logic [31:0] TIN [NV] = '{mk_t(10,20,30), mk_t(10,20,59), mk_t(10,59,59),
    mk_t(23,59,59), mk_t(23,59,59), mk_t(23,59,59), mk_t(23,59,59), mk_t(23,59,59),
    mk_t(23,59,59), mk_t(23,59,59), mk_t(23,59,59), mk_t(23,59,59), mk_t(23,59,59)};
  localparam logic [31:0] DIN [NV] = '{mk_d(1,30,5,6), mk_d(0,31,7,14), mk_d(0,31,7,14),
    mk_d(0,31,4,30), mk_d(0,31,1,31), mk_d(0,31,2,28), mk_d(1,30,2,28), mk_d(1,30,2,29),
    mk_d(0,29,12,31), mk_d(1,30,12,31), mk_d(0,63,12,31), mk_d(0,31,9,15), mk_d(0,31,11,30)};
  localparam logic [31:0] TEX [NV] = '{mk_t(10,20,31), mk_t(10,21,0), mk_t(11,0,0),
    mk_t(0,0,0), mk_t(0,0,0), mk_t(0,0,0), mk_t(0,0,0), mk_t(0,0,0),
    mk_t(0,0,0), mk_t(0,0,0), mk_t(0,0,0), mk_t(0,0,0), mk_t(0,0,0)};
  localparam logic [31:0] DEX [NV] = '{mk_d(1,30,5,6), mk_d(0,31,7,14), mk_d(0,31,7,14),
    mk_d(0,31,5,1), mk_d(0,31,2,1), mk_d(0,31,3,1), mk_d(1,30,2,29), mk_d(1,30,3,1),
    mk_d(1,30,1,1), mk_d(0,31,1,1), mk_d(0,0,1,1), mk_d(0,31,9,16), mk_d(0,31,12,1)};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_TIME, v); chk("R1 time", v, 32'h0);
    rd(A_DATE, v); chk("R1 date", v, 32'h0000_0101);

    // R9 control and unmapped writes ignored, no tick no change
    wr(A_CTRL, 32'hFFFF_FFFF);
    wr(8'h20, 32'h0012_3456);
    repeat (20) @(negedge clk);
    rd(A_CTRL, v); chk("R9 ctrl", v, 32'h0);
    rd(A_TIME, v); chk("R9 time", v, 32'h0);
    rd(A_DATE, v); chk("R9 date", v, 32'h0000_0101);

    // R3 plain seconds advance
    repeat (3) tick();
    rd(A_TIME, v); chk("R3 three ticks", v, mk_t(0,0,3));

    // R7 / R10 time write
    wr(A_TIME, mk_t(5,6,7));
    rd(A_CTRL, v); chk("R7 busy set", v, 32'h100);
    repeat (5) @(negedge clk);
    rd(A_TIME, v); chk("R10 pending hidden", v, mk_t(0,0,3));
    rd(A_CTRL, v); chk("R7 busy held", v, 32'h100);
    tick();
    rd(A_CTRL, v); chk("R7 busy clear", v, 32'h0);
    rd(A_TIME, v); chk("R7 committed", v, mk_t(5,6,7));

    // R8 date write, no advance on commit tick
    wr(A_DATE, mk_d(1,42,3,9));
    rd(A_CTRL, v); chk("R8 busy set", v, 32'h080);
    rd(A_DATE, v); chk("R10 date hidden", v, 32'h0000_0101);
    tick();
    rd(A_CTRL, v); chk("R8 busy clear", v, 32'h0);
    rd(A_DATE, v); chk("R8 committed", v, mk_d(1,42,3,9));
    rd(A_TIME, v); chk("R8 no advance on commit", v, mk_t(5,6,7));

    // R7/R8 both pending
    wr(A_TIME, mk_t(12,0,0));
    wr(A_DATE, mk_d(0,10,8,20));
    rd(A_CTRL, v); chk("R8 both busy", v, 32'h180);
    tick();
    rd(A_CTRL, v); chk("R7 both clear", v, 32'h0);

    // R7 write in the same cycle as a tick is not committed by it
    @(negedge clk); reg_wr = 1'b1; reg_addr = A_TIME; reg_wdata = mk_t(1,2,3); sec_tick = 1'b1;
    @(negedge clk); reg_wr = 1'b0; sec_tick = 1'b0;
    rd(A_TIME, v); chk("R7 same-cycle advance", v, mk_t(12,0,1));
    rd(A_CTRL, v); chk("R7 same-cycle busy", v, 32'h100);
    tick();
    rd(A_TIME, v); chk("R7 same-cycle commit", v, mk_t(1,2,3));

    // R7 overwrite while pending
    wr(A_TIME, mk_t(4,4,4));
    wr(A_TIME, mk_t(9,8,7));
    tick();
    rd(A_TIME, v); chk("R7 last write wins", v, mk_t(9,8,7));

    // R2..R6 boundary table: commit then one second advance
    for (int i = 0; i < NV; i++) begin
      wr(A_TIME, TIN[i]);
      wr(A_DATE, DIN[i]);
      tick();
      rd(A_TIME, v); chk($sformatf("R2 row %0d time load", i), v, TIN[i]);
      rd(A_DATE, v); chk($sformatf("R2 row %0d date load", i), v, DIN[i]);
      tick();
      rd(A_TIME, v); chk($sformatf("R3/R4 row %0d time", i), v, TEX[i]);
      rd(A_DATE, v); chk($sformatf("R4/R5/R6 row %0d date", i), v, DEX[i]);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule